// File: doc/BRIEF.md
# Branch Target Predictor Table

This block predicts the next fetch address in the first fetch stage. It is a direct-mapped table. A field of low address bits, taken from the fetch address just above the instruction alignment bits, selects one entry. Each entry holds a valid flag, the full address of a control instruction and the target that instruction last jumped to. When the fetch address matches a live entry in full, the block predicts that target. Otherwise it predicts the next sequential instruction, which is the fetch address plus four. Because the whole address is compared, an ordinary instruction that shares an index with a stored branch never picks up that branch's target.

The execute stage reports each resolved control instruction through a second port. That report carries the instruction address, the taken outcome, the real target and the next address that fetch had predicted. A taken outcome writes or refreshes the entry. A not-taken outcome whose address matches the entry removes it, so only taken transfers stay in the table. The block compares the real next address with the prediction. One cycle later it raises a mispredict flag and gives the address that fetch must restart from.

Top module: `btb_predictor`

## Requirements
- R1: While reset is high, `pred_valid` and `mispredict` are 0. After reset every entry is empty, so every lookup misses until something is installed.
- R2: A lookup presented with `fetch_req` high at a clock edge yields `pred_valid`=1 after that edge. When `fetch_req` was low, `pred_valid` is 0.
- R3: A lookup hits (`pred_hit`=1) only when the selected entry is valid and its stored address equals the fetch address in all bits. On a hit, `pred_next_pc` is the stored target.
- R4: On a miss, `pred_next_pc` is `pred_pc` + 4.
- R5: The entry index is fetch address bits [5:2] with the default parameters (IDX_W=4, ALIGN_W=2), giving 16 entries. An address that differs only above bit 5 misses, and installing it replaces the older entry.
- R6: A resolution with `res_taken`=1 sets that entry to valid, with the resolved address and `res_target`. This either installs a new entry or refreshes an existing one.
- R7: A resolution with `res_taken`=0 empties the entry only if the entry is valid and holds the same full address. Otherwise the table is unchanged.
- R8: One cycle after a resolution, `redirect_pc` is the real next address: `res_target` when taken, `res_pc`+4 when not taken. `mispredict` is 1 exactly when that address differs from `res_pred_next`. `mispredict` is 0 after a cycle with no resolution.
- R9: When a lookup and an update address the same entry in the same cycle, the lookup returns the entry's contents from before the update.
- R10: Resolution fields have no effect while `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Lookup request |
| fetch_pc | input | PC_W | Address being fetched |
| pred_valid | output | 1 | A lookup result is present |
| pred_hit | output | 1 | The lookup matched a live entry |
| pred_pc | output | PC_W | Address of the lookup whose result is shown |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | A resolved control instruction is reported |
| res_pc | input | PC_W | Address of the resolved instruction |
| res_taken | input | 1 | The instruction transferred control |
| res_target | input | PC_W | Real target of the transfer |
| res_pred_next | input | PC_W | Next address that fetch predicted for it |
| mispredict | output | 1 | The prediction was wrong |
| redirect_pc | output | PC_W | Correct next fetch address |

## Verification
Each lookup result is due one clock edge after the request. Each mispredict flag and redirect address is due one edge after its resolution. A table change made by a resolution is first visible to a lookup issued at the following edge. The bench drives inputs on the falling edge and samples one falling edge later, so every result is read half a cycle after the edge that registered it. A reference table in the bench, updated only after the expected values have been taken, gives the old-contents answer when a lookup and an update meet on one entry.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_WRITE = 2'd1,
    UPD_CLEAR = 2'd2
  } btb_upd_e;
endpackage

// File: rtl/btb_tag_array.sv
module btb_tag_array
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_req,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  input  btb_upd_e        upd_act,
  input  logic [PC_W-1:0] upd_pc,
  output logic            upd_match
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [IDX_W-1:0]   lk_idx, upd_idx;

  assign lk_idx    = lk_pc[ALIGN_W +: IDX_W];
  assign upd_idx   = upd_pc[ALIGN_W +: IDX_W];
  assign upd_match = vld_q[upd_idx] && (tag_q[upd_idx] == upd_pc);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      case (upd_act)
        UPD_WRITE: vld_q[upd_idx] <= 1'b1;
        UPD_CLEAR: vld_q[upd_idx] <= 1'b0;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (upd_act == UPD_WRITE) tag_q[upd_idx] <= upd_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) lk_hit <= 1'b0;
    else     lk_hit <= lk_req && vld_q[lk_idx] && (tag_q[lk_idx] == lk_pc);
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) rst |=> (vld_q == '0));
  // R6
  install_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_act == UPD_WRITE) |=> (vld_q[$past(upd_idx)] && tag_q[$past(upd_idx)] == $past(upd_pc)));
  // R7
  remove_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_act == UPD_CLEAR) |=> !vld_q[$past(upd_idx)]);
  // R10
  idle_table_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_act == UPD_NONE) |=> $stable(vld_q));
endmodule

// File: rtl/btb_target_ram.sv
module btb_target_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/btb_resolver.sv
module btb_resolver
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic [PC_W-1:0] res_pred_next,
  input  logic            upd_match,
  output btb_upd_e        upd_act,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN_W;

  logic [PC_W-1:0] actual_next;

  assign actual_next = res_taken ? res_target : (res_pc + STEP);

  always_comb begin
    upd_act = UPD_NONE;
    if (res_valid) begin
      if (res_taken)      upd_act = UPD_WRITE;
      else if (upd_match) upd_act = UPD_CLEAR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict  <= 1'b0;
      redirect_pc <= '0;
    end else begin
      mispredict  <= res_valid && (actual_next != res_pred_next);
      if (res_valid) redirect_pc <= actual_next;
    end
  end

  // R8
  mispredict_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (mispredict == (redirect_pc != $past(res_pred_next))));
  // R8
  no_res_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> !mispredict);
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_req,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_pc,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic [PC_W-1:0] res_pred_next,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN_W;

  btb_upd_e        upd_act;
  logic            upd_match;
  logic [PC_W-1:0] tgt_rd;

  btb_tag_array #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_tags (
    .clk(clk), .rst(rst),
    .lk_req(fetch_req), .lk_pc(fetch_pc), .lk_hit(pred_hit),
    .upd_act(upd_act), .upd_pc(res_pc), .upd_match(upd_match)
  );

  btb_target_ram #(.DATA_W(PC_W), .ADDR_W(IDX_W)) u_targets (
    .clk(clk),
    .we(upd_act == UPD_WRITE),
    .waddr(res_pc[ALIGN_W +: IDX_W]),
    .wdata(res_target),
    .raddr(fetch_pc[ALIGN_W +: IDX_W]),
    .rdata(tgt_rd)
  );

  btb_resolver #(.PC_W(PC_W), .ALIGN_W(ALIGN_W)) u_resolve (
    .clk(clk), .rst(rst),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_pred_next(res_pred_next),
    .upd_match(upd_match), .upd_act(upd_act),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_pc    <= '0;
    end else begin
      pred_valid <= fetch_req;
      if (fetch_req) pred_pc <= fetch_pc;
    end
  end

  assign pred_next_pc = pred_hit ? tgt_rd : (pred_pc + STEP);

  // R2
  lookup_latency_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> pred_valid);
  // R2
  no_lookup_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_req |=> !pred_valid);
  // R3
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    pred_hit |-> pred_valid);
endmodule

// File: tb/test_btb_predictor.sv
module test_btb_predictor;
  localparam int PC_W = 32;
  localparam int IDX_W = 4;
  localparam int N = 1 << IDX_W;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_req = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic pred_valid, pred_hit;
  logic [31:0] pred_pc, pred_next_pc;
  logic res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic res_taken = 1'b0;
  logic [31:0] res_target = '0;
  logic [31:0] res_pred_next = '0;
  logic mispredict;
  logic [31:0] redirect_pc;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  bit          m_vld [N];
  logic [31:0] m_tag [N];
  logic [31:0] m_tgt [N];

  always #5 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(2)) i_btb_predictor (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_pc(pred_pc),
    .pred_next_pc(pred_next_pc), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target), .res_pred_next(res_pred_next),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  function automatic int idx_of(input logic [31:0] pc);
    return int'((pc >> 2) & (N - 1));
  endfunction

  function automatic bit m_hit(input logic [31:0] pc);
    return m_vld[idx_of(pc)] && (m_tag[idx_of(pc)] == pc);
  endfunction

  function automatic logic [31:0] m_next(input logic [31:0] pc);
    return m_hit(pc) ? m_tgt[idx_of(pc)] : pc + 32'd4;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_update(input logic [31:0] pc, input bit taken, input logic [31:0] tgt);
    if (taken) begin
      m_vld[idx_of(pc)] = 1'b1;
      m_tag[idx_of(pc)] = pc;
      m_tgt[idx_of(pc)] = tgt;
    end else if (m_hit(pc)) begin
      m_vld[idx_of(pc)] = 1'b0;
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input string req);
    bit e_hit;
    logic [31:0] e_next;
    e_hit = m_hit(pc);
    e_next = m_next(pc);
    fetch_req = 1'b1;
    fetch_pc = pc;
    @(negedge clk);
    fetch_req = 1'b0;
    check({req, " R2 valid"}, 32'(pred_valid), 32'd1);
    check({req, " hit"}, 32'(pred_hit), 32'(e_hit));
    check({req, " next"}, pred_next_pc, e_next);
  endtask

  task automatic resolve(input logic [31:0] pc, input bit taken, input logic [31:0] tgt,
                         input logic [31:0] pred, input string req);
    logic [31:0] act_next;
    act_next = taken ? tgt : pc + 32'd4;
    res_valid = 1'b1;
    res_pc = pc;
    res_taken = taken;
    res_target = tgt;
    res_pred_next = pred;
    m_update(pc, taken, tgt);
    @(negedge clk);
    res_valid = 1'b0;
    check({req, " R8 mispredict"}, 32'(mispredict), 32'(act_next != pred));
    check({req, " R8 redirect"}, redirect_pc, act_next);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    fetch_req = 1'b1;
    fetch_pc = BASE;
    res_valid = 1'b1;
    res_taken = 1'b1;
    res_pc = BASE;
    res_pred_next = 32'hdead_beef;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 pred_valid in reset", 32'(pred_valid), 32'd0);
    check("R1 mispredict in reset", 32'(mispredict), 32'd0);
    fetch_req = 1'b0;
    res_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle valid", 32'(pred_valid), 32'd0);

    // R1 R4: empty table, sequential prediction everywhere
    for (int i = 0; i < N; i++) lookup(BASE + 32'(i * 4), "R1 R4 empty");

    // R6: install every entry, fetch had predicted fall-through
    for (int i = 0; i < N; i++)
      resolve(BASE + 32'(i * 4), 1'b1, 32'h0000_8000 + 32'(i * 256), BASE + 32'(i * 4) + 32'd4, "R6 install");
    // R3: all hit
    for (int i = 0; i < N; i++) lookup(BASE + 32'(i * 4), "R3 hit");

    // R5: aliases differing above bit 5 miss, then replace on even entries
    for (int i = 0; i < N; i++) lookup(BASE + 32'h40 + 32'(i * 4), "R5 alias miss");
    for (int i = 0; i < N; i += 2)
      resolve(BASE + 32'h40 + 32'(i * 4), 1'b1, 32'h0000_9000 + 32'(i * 16), BASE + 32'h44 + 32'(i * 4), "R5 replace");
    for (int i = 0; i < N; i++) begin
      lookup(BASE + 32'(i * 4), "R5 original");
      lookup(BASE + 32'h40 + 32'(i * 4), "R5 alias");
    end

    // R7: not-taken with non-matching address leaves odd entries alone
    for (int i = 1; i < N; i += 2)
      resolve(BASE + 32'h40 + 32'(i * 4), 1'b0, 32'h0, BASE + 32'h44 + 32'(i * 4), "R7 foreign not-taken");
    for (int i = 1; i < N; i += 2) lookup(BASE + 32'(i * 4), "R7 kept");
    // R7 R8: not-taken matching clears, predicted target was wrong
    for (int i = 1; i < N; i += 2)
      resolve(BASE + 32'(i * 4), 1'b0, 32'h0, m_next(BASE + 32'(i * 4)), "R7 clear");
    for (int i = 0; i < N; i++) lookup(BASE + 32'(i * 4), "R7 after clear");

    // R8: correct taken prediction, then R6 refresh with new target
    resolve(BASE + 32'h40, 1'b1, m_next(BASE + 32'h40), m_next(BASE + 32'h40), "R8 correct");
    resolve(BASE + 32'h40, 1'b1, 32'h0000_a000, m_next(BASE + 32'h40), "R6 refresh");
    lookup(BASE + 32'h40, "R6 refreshed");

    // R10: fields present but res_valid low
    res_valid = 1'b0;
    res_taken = 1'b1;
    res_pc = BASE + 32'h4;
    res_target = 32'h0000_bbbb;
    res_pred_next = 32'h0;
    @(negedge clk);
    check("R10 mispredict", 32'(mispredict), 32'd0);
    lookup(BASE + 32'h4, "R10 untouched");
    res_taken = 1'b0;
    res_pc = BASE + 32'h40;
    @(negedge clk);
    lookup(BASE + 32'h40, "R10 no clear");

    // R9: lookup and install at the same entry in one cycle
    begin
      logic [31:0] pc;
      bit e_hit;
      logic [31:0] e_next;
      pc = BASE + 32'hc;
      e_hit = m_hit(pc);
      e_next = m_next(pc);
      fetch_req = 1'b1;
      fetch_pc = pc;
      res_valid = 1'b1;
      res_pc = pc;
      res_taken = 1'b1;
      res_target = 32'h0000_c000;
      res_pred_next = e_next;
      m_update(pc, 1'b1, 32'h0000_c000);
      @(negedge clk);
      fetch_req = 1'b0;
      res_valid = 1'b0;
      check("R9 old hit", 32'(pred_hit), 32'(e_hit));
      check("R9 old next", pred_next_pc, e_next);
      lookup(pc, "R9 new");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule